// File: doc/BRIEF.md
# Multi-Source CAN Transmit Arbiter

This block sits between a host register port and a CAN controller. It holds frames from four kinds of transmit source and hands the controller one frame at a time. The four sources are a first-in first-out queue, a table of periodic entries, a table of entries that fire when a matching frame is received, and a single direct slot that bypasses the queue. Every cycle, a comparator chain ranks all pending frames by CAN bus dominance. The frame that would win arbitration on the wire is the one offered.

The host writes a whole frame record or configuration record in one cycle through `host_op`. The op codes are: 0 queue push, 1 direct load, 2 periodic data, 3 periodic configuration, 4 response data, 5 response match. A small state machine runs the controller handshake. Its states are IDLE, OFFER and SEND. Its transitions are START (IDLE to OFFER when any frame is pending) and SWAP (OFFER to OFFER when the winner changes before a take). WITHDRAW goes from OFFER to IDLE when nothing is pending any more. TAKE goes from OFFER to SEND when the controller asserts `tx_take`. DONE goes from SEND to IDLE when `tx_done` is asserted. On DONE the source entry that was sent is retired.

The periodic table counts ticks of a fixed interval. One tick lasts `TICK_DIV` clocks, which is 1 ms at the default setting. Each entry carries a 14-bit period and an enable bit.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset `tx_valid` is low and no source holds a pending frame, so nothing is offered until the host writes a frame.
- R2: Among pending frames, the one with the lowest dominance key is offered. The key is formed as follows. The base identifier is id[10:0] for standard frames and id[28:18] for extended frames. Next comes a bit that is RTR for standard frames and 1 for extended frames. Then come the extended flag, then id[17:0] (zero for standard frames), then RTR for extended frames (zero for standard frames). As a result, standard beats extended on equal base, and data beats remote.
- R3: When two sources hold frames with equal keys, the source rank decides: direct before responsive, responsive before periodic, periodic before queued. `tx_src` reports the rank as 0, 1, 2 or 3 respectively.
- R4: Queued frames leave in push order. The queue holds `QDEPTH` frames (default 48), and a push to a full queue is dropped.
- R5: A direct load (op 1) makes the direct slot pending at once. The slot holds one frame and is retired when that frame is reported sent.
- R6: A periodic entry with a nonzero period P and its enable bit set becomes pending every P ticks after its configuration write (op 3). A tick is `TICK_DIV` clocks. An entry that is disabled or has period 0 never fires.
- R7: A periodic data write (op 2) replaces the frame without disturbing the entry's count phase.
- R8: A response entry fires on a received frame under two conditions. First, its identifier must match: all 29 bits against an extended frame in extended mode, or id[10:0] against a standard frame in standard mode. Second, when RTR checking is on, the RTR bit must equal the configured one. Other received frames are ignored.
- R9: `tx_valid` stays high until `tx_take`. After a take, `tx_valid` is low and the frame outputs are held until `tx_done`. After `tx_done`, at least one idle cycle passes before the next offer.
- R10: An entry being written in a cycle is not eligible in that cycle. Until the take, the offered frame is replaced whenever a more dominant frame becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_op | input | 3 | Write target and kind (op codes 0 to 5) |
| host_idx | input | IDX_W | Table entry for ops 2 to 5 |
| host_id | input | 29 | Frame identifier, or match identifier for op 5 |
| host_ext | input | 1 | Extended-frame flag, or match mode for op 5 |
| host_rtr | input | 1 | Remote flag, or RTR value to match for op 5 |
| host_dlc | input | 4 | Data length code |
| host_data | input | 64 | Frame payload |
| host_period | input | 14 | Periodic interval in ticks (op 3) |
| host_en | input | 1 | Entry enable (ops 3 and 5) |
| host_rtr_chk | input | 1 | Require RTR match (op 5) |
| rx_valid | input | 1 | Received-frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_ext | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is remote |
| tx_valid | output | 1 | A frame is offered |
| tx_id | output | 29 | Offered identifier |
| tx_ext | output | 1 | Offered extended flag |
| tx_rtr | output | 1 | Offered remote flag |
| tx_dlc | output | 4 | Offered data length code |
| tx_data | output | 64 | Offered payload |
| tx_src | output | 2 | Source rank of the offered frame |
| tx_take | input | 1 | Controller accepts the offered frame |
| tx_done | input | 1 | Controller finished sending the taken frame |

## Verification
The checker watches the handshake on every cycle. It confirms that a take drops `tx_valid` and that nothing is offered while a frame is in flight. It also confirms that the in-flight frame stays unchanged until done, that done always returns to idle, that the queue occupancy never exceeds its depth, and that a direct load always arms the slot.

Only the bench scenarios can show the ranking itself. The bench sweeps every ordered pair from a set of six frames, covering standard and extended frames, data and remote frames, and equal and adjacent identifiers. Only the bench can also show FIFO order and overflow drop, the exact periodic interval across a data update, and which received frames do or do not trigger a response.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;

    typedef struct packed {
        logic [28:0] id;
        logic        ext;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
    } can_frame_t;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_RESP   = 2'd1,
        SRC_SCHED  = 2'd2,
        SRC_QUEUE  = 2'd3
    } tx_src_e;

    typedef enum logic [2:0] {
        OP_QUEUE_PUSH  = 3'd0,
        OP_DIRECT_LOAD = 3'd1,
        OP_SCHED_DATA  = 3'd2,
        OP_SCHED_CFG   = 3'd3,
        OP_RESP_DATA   = 3'd4,
        OP_RESP_MATCH  = 3'd5
    } host_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_SEND  = 2'd2
    } arb_state_e;

    // Bus arbitration order: lower key wins on the wire.
    function automatic logic [31:0] dominance_key(input can_frame_t f);
        logic [10:0] base;
        logic [17:0] tail;
        base = f.ext ? f.id[28:18] : f.id[10:0];
        tail = f.ext ? f.id[17:0] : 18'd0;
        return {base, (f.ext ? 1'b1 : f.rtr), f.ext, tail, (f.ext & f.rtr)};
    endfunction

endpackage

// File: rtl/can_tx_queue.sv
module can_tx_queue
    import can_arb_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  can_frame_t push_frame,
    input  logic       pop,
    output can_frame_t head,
    output logic       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    can_frame_t      mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic            do_push;
    logic            do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            end
            if (do_push && !do_pop) begin
                count <= count + CW'(1);
            end else if (do_pop && !do_push) begin
                count <= count - CW'(1);
            end
        end
    end
endmodule

// File: rtl/can_sched_table.sv
module can_sched_table
    import can_arb_pkg::*;
#(
    parameter int N        = 4,
    parameter int IDX_W    = 2,
    parameter int TICK_DIV = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  can_frame_t       wr_frame,
    input  logic [13:0]      wr_period,
    input  logic             wr_en,
    input  logic             clr,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     pend,
    output can_frame_t       frames [N]
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic          tick;

    assign tick = (div_cnt == DW'(TICK_DIV-1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + DW'(1);
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [13:0] period_r;
        logic [13:0] cnt_r;
        logic        en_r;
        logic        live;
        logic        fire;
        logic        sel_cfg;
        logic        sel_clr;

        assign live    = tick && en_r && (period_r != 14'd0);
        assign fire    = live && (cnt_r <= 14'd1);
        assign sel_cfg = cfg_we && (wr_idx == IDX_W'(g));
        assign sel_clr = clr && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                period_r <= '0;
                cnt_r    <= '0;
                en_r     <= 1'b0;
                pend[g]  <= 1'b0;
            end else if (sel_cfg) begin
                period_r <= wr_period;
                cnt_r    <= wr_period;
                en_r     <= wr_en;
                pend[g]  <= 1'b0;
            end else begin
                if (live) begin
                    cnt_r <= fire ? period_r : cnt_r - 14'd1;
                end
                if (fire) begin
                    pend[g] <= 1'b1;
                end else if (sel_clr) begin
                    pend[g] <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frames[g] <= '0;
            end else if (data_we && (wr_idx == IDX_W'(g))) begin
                frames[g] <= wr_frame;
            end
        end
    end
endmodule

// File: rtl/can_resp_table.sv
module can_resp_table
    import can_arb_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_we,
    input  logic             data_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  can_frame_t       wr_frame,
    input  logic             wr_rtr_chk,
    input  logic             wr_en,
    input  logic             rx_valid,
    input  logic [28:0]      rx_id,
    input  logic             rx_ext,
    input  logic             rx_rtr,
    input  logic             clr,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     pend,
    output can_frame_t       frames [N]
);
    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [28:0] m_id;
        logic        m_ext;
        logic        m_rtr;
        logic        m_chk;
        logic        m_en;
        logic        id_hit;
        logic        fire;
        logic        sel_match;

        assign id_hit = m_ext ? (rx_ext && (rx_id == m_id))
                              : (!rx_ext && (rx_id[10:0] == m_id[10:0]));
        assign fire = rx_valid && m_en && id_hit && (!m_chk || (rx_rtr == m_rtr));
        assign sel_match = match_we && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_id    <= '0;
                m_ext   <= 1'b0;
                m_rtr   <= 1'b0;
                m_chk   <= 1'b0;
                m_en    <= 1'b0;
                pend[g] <= 1'b0;
            end else if (sel_match) begin
                m_id    <= wr_frame.id;
                m_ext   <= wr_frame.ext;
                m_rtr   <= wr_frame.rtr;
                m_chk   <= wr_rtr_chk;
                m_en    <= wr_en;
                pend[g] <= 1'b0;
            end else if (fire) begin
                pend[g] <= 1'b1;
            end else if (clr && (clr_idx == IDX_W'(g))) begin
                pend[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frames[g] <= '0;
            end else if (data_we && (wr_idx == IDX_W'(g))) begin
                frames[g] <= wr_frame;
            end
        end
    end
endmodule

// File: rtl/can_arb_select.sv
module can_arb_select
    import can_arb_pkg::*;
#(
    parameter int N = 10,
    parameter int W = 4
) (
    input  logic [N-1:0] vld,
    input  can_frame_t   frm [N],
    input  tx_src_e      src [N],
    output logic         any,
    output logic [W-1:0] win
);
    logic [33:0] best;
    logic [33:0] key;

    // Linear scan: strict less-than keeps the lower slot on a full tie.
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '1;
        key  = '0;
        for (int i = 0; i < N; i++) begin
            key = {dominance_key(frm[i]), src[i]};
            if (vld[i] && (!any || (key < best))) begin
                any  = 1'b1;
                best = key;
                win  = W'(i);
            end
        end
    end
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
    import can_arb_pkg::*;
#(
    parameter int QDEPTH   = 48,
    parameter int NSCHED   = 4,
    parameter int NRESP    = 4,
    parameter int IDX_W    = 2,
    parameter int TICK_DIV = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [2:0]       host_op,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [28:0]      host_id,
    input  logic             host_ext,
    input  logic             host_rtr,
    input  logic [3:0]       host_dlc,
    input  logic [63:0]      host_data,
    input  logic [13:0]      host_period,
    input  logic             host_en,
    input  logic             host_rtr_chk,
    input  logic             rx_valid,
    input  logic [28:0]      rx_id,
    input  logic             rx_ext,
    input  logic             rx_rtr,
    output logic             tx_valid,
    output logic [28:0]      tx_id,
    output logic             tx_ext,
    output logic             tx_rtr,
    output logic [3:0]       tx_dlc,
    output logic [63:0]      tx_data,
    output logic [1:0]       tx_src,
    input  logic             tx_take,
    input  logic             tx_done
);
    localparam int NC    = 2 + NSCHED + NRESP;
    localparam int CW    = $clog2(NC);
    localparam int QCW   = $clog2(QDEPTH + 1);
    localparam int RBASE = 1;
    localparam int SBASE = 1 + NRESP;
    localparam int QSLOT = NC - 1;

    host_op_e   op;
    can_frame_t wr_frame;
    logic       wr_q, wr_dir, wr_sdat, wr_scfg, wr_rdat, wr_rmat;

    assign op       = host_op_e'(host_op);
    assign wr_frame = '{id: host_id, ext: host_ext, rtr: host_rtr, dlc: host_dlc, data: host_data};
    assign wr_q     = host_we && (op == OP_QUEUE_PUSH);
    assign wr_dir   = host_we && (op == OP_DIRECT_LOAD);
    assign wr_sdat  = host_we && (op == OP_SCHED_DATA);
    assign wr_scfg  = host_we && (op == OP_SCHED_CFG);
    assign wr_rdat  = host_we && (op == OP_RESP_DATA);
    assign wr_rmat  = host_we && (op == OP_RESP_MATCH);

    arb_state_e st, st_nx;
    logic [CW-1:0] win_r;
    can_frame_t    offer_r;
    tx_src_e       src_r;
    logic          retire;
    logic          sending;

    assign retire  = (st == ST_SEND) && tx_done;
    assign sending = (st == ST_SEND);

    // ---------------- retire decode ----------------
    logic             clr_rsp, clr_sch, clr_q, clr_dir;
    logic [IDX_W-1:0] clr_rsp_idx, clr_sch_idx;
    logic [CW-1:0]    rsp_off, sch_off;

    assign rsp_off     = win_r - CW'(RBASE);
    assign sch_off     = win_r - CW'(SBASE);
    assign clr_dir     = retire && (win_r == '0);
    assign clr_rsp     = retire && (win_r >= CW'(RBASE)) && (win_r < CW'(SBASE));
    assign clr_sch     = retire && (win_r >= CW'(SBASE)) && (win_r < CW'(QSLOT));
    assign clr_q       = retire && (win_r == CW'(QSLOT));
    assign clr_rsp_idx = IDX_W'(rsp_off);
    assign clr_sch_idx = IDX_W'(sch_off);

    // ---------------- direct slot ----------------
    logic       dir_pend;
    can_frame_t dir_frame;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_pend  <= 1'b0;
            dir_frame <= '0;
        end else if (wr_dir) begin
            dir_pend  <= 1'b1;
            dir_frame <= wr_frame;
        end else if (clr_dir) begin
            dir_pend  <= 1'b0;
        end
    end

    // ---------------- sources ----------------
    logic [NRESP-1:0]  rsp_pend;
    can_frame_t        rsp_frames [NRESP];
    logic [NSCHED-1:0] sch_pend;
    can_frame_t        sch_frames [NSCHED];
    can_frame_t        q_head;
    logic              q_empty;
    logic [QCW-1:0]    q_count;

    can_tx_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_q),
        .push_frame (wr_frame),
        .pop        (clr_q),
        .head       (q_head),
        .empty      (q_empty),
        .count      (q_count)
    );

    can_sched_table #(.N(NSCHED), .IDX_W(IDX_W), .TICK_DIV(TICK_DIV)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (wr_sdat),
        .cfg_we    (wr_scfg),
        .wr_idx    (host_idx),
        .wr_frame  (wr_frame),
        .wr_period (host_period),
        .wr_en     (host_en),
        .clr       (clr_sch),
        .clr_idx   (clr_sch_idx),
        .pend      (sch_pend),
        .frames    (sch_frames)
    );

    can_resp_table #(.N(NRESP), .IDX_W(IDX_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_we   (wr_rmat),
        .data_we    (wr_rdat),
        .wr_idx     (host_idx),
        .wr_frame   (wr_frame),
        .wr_rtr_chk (host_rtr_chk),
        .wr_en      (host_en),
        .rx_valid   (rx_valid),
        .rx_id      (rx_id),
        .rx_ext     (rx_ext),
        .rx_rtr     (rx_rtr),
        .clr        (clr_rsp),
        .clr_idx    (clr_rsp_idx),
        .pend       (rsp_pend),
        .frames     (rsp_frames)
    );

    // ---------------- candidate list ----------------
    logic [NC-1:0] cand_vld;
    can_frame_t    cand_frm [NC];
    tx_src_e       cand_src [NC];

    assign cand_vld[0] = dir_pend && !wr_dir;
    assign cand_frm[0] = dir_frame;
    assign cand_src[0] = SRC_DIRECT;

    for (genvar g = 0; g < NRESP; g++) begin : g_rc
        assign cand_vld[RBASE+g] = rsp_pend[g] &&
                                   !((wr_rdat || wr_rmat) && (host_idx == IDX_W'(g)));
        assign cand_frm[RBASE+g] = rsp_frames[g];
        assign cand_src[RBASE+g] = SRC_RESP;
    end

    for (genvar g = 0; g < NSCHED; g++) begin : g_sc
        assign cand_vld[SBASE+g] = sch_pend[g] &&
                                   !((wr_sdat || wr_scfg) && (host_idx == IDX_W'(g)));
        assign cand_frm[SBASE+g] = sch_frames[g];
        assign cand_src[SBASE+g] = SRC_SCHED;
    end

    assign cand_vld[QSLOT] = !q_empty;
    assign cand_frm[QSLOT] = q_head;
    assign cand_src[QSLOT] = SRC_QUEUE;

    logic          any;
    logic [CW-1:0] win;

    can_arb_select #(.N(NC), .W(CW)) u_select (
        .vld (cand_vld),
        .frm (cand_frm),
        .src (cand_src),
        .any (any),
        .win (win)
    );

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (any) st_nx = ST_OFFER;          // START
            ST_OFFER: begin
                if (tx_take)   st_nx = ST_SEND;           // TAKE
                else if (!any) st_nx = ST_IDLE;           // WITHDRAW
                else           st_nx = ST_OFFER;          // SWAP / hold
            end
            ST_SEND:  if (tx_done) st_nx = ST_IDLE;       // DONE
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Offer register: reloaded with the current winner until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_r <= '0;
            win_r   <= '0;
            src_r   <= SRC_DIRECT;
        end else if (any && ((st == ST_IDLE) || ((st == ST_OFFER) && !tx_take))) begin
            offer_r <= cand_frm[win];
            win_r   <= win;
            src_r   <= cand_src[win];
        end
    end

    always_comb begin
        tx_valid = (st == ST_OFFER);
        tx_id    = offer_r.id;
        tx_ext   = offer_r.ext;
        tx_rtr   = offer_r.rtr;
        tx_dlc   = offer_r.dlc;
        tx_data  = offer_r.data;
        tx_src   = src_r;
    end
endmodule

// File: rtl/can_arb_checker.sv
module can_arb_checker #(
    parameter int QDEPTH = 48,
    parameter int QCW    = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tx_valid,
    input logic           tx_take,
    input logic           tx_done,
    input logic [28:0]    tx_id,
    input logic [63:0]    tx_data,
    input logic           sending,
    input logic [QCW-1:0] q_count,
    input logic           host_we,
    input logic [2:0]     host_op,
    input logic           dir_pend
);
    AST_TAKE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_take) |=> (!tx_valid && sending)); // R9

    AST_NO_OFFER_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        sending |-> !tx_valid); // R9

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !tx_done) |=> ($stable(tx_id) && $stable(tx_data))); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && tx_done) |=> (!sending && !tx_valid)); // R9

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(QDEPTH)); // R4

    AST_DIRECT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_op == 3'd1) |=> dir_pend); // R5
endmodule

bind can_tx_arbiter can_arb_checker #(.QDEPTH(QDEPTH), .QCW(QCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_take  (tx_take),
    .tx_done  (tx_done),
    .tx_id    (tx_id),
    .tx_data  (tx_data),
    .sending  (sending),
    .q_count  (q_count),
    .host_we  (host_we),
    .host_op  (host_op),
    .dir_pend (dir_pend)
);

// File: tb/tb_can_tx_arbiter.sv
module tb_can_tx_arbiter;
    localparam int TICK = 10;
    localparam int QD   = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_op = '0;
    logic [1:0]  host_idx = '0;
    logic [28:0] host_id = '0;
    logic        host_ext = 1'b0, host_rtr = 1'b0;
    logic [3:0]  host_dlc = '0;
    logic [63:0] host_data = '0;
    logic [13:0] host_period = '0;
    logic        host_en = 1'b0, host_rtr_chk = 1'b0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0, rx_rtr = 1'b0;
    logic        tx_valid;
    logic [28:0] tx_id;
    logic        tx_ext, tx_rtr;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic [1:0]  tx_src;
    logic        tx_take = 1'b0, tx_done = 1'b0;

    always #5 clk = ~clk;

    can_tx_arbiter #(.QDEPTH(QD), .TICK_DIV(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_op(host_op), .host_idx(host_idx),
        .host_id(host_id), .host_ext(host_ext), .host_rtr(host_rtr), .host_dlc(host_dlc),
        .host_data(host_data), .host_period(host_period), .host_en(host_en),
        .host_rtr_chk(host_rtr_chk), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ext(rx_ext),
        .rx_rtr(rx_rtr), .tx_valid(tx_valid), .tx_id(tx_id), .tx_ext(tx_ext), .tx_rtr(tx_rtr),
        .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_src(tx_src), .tx_take(tx_take), .tx_done(tx_done)
    );

    int      vectors = 0;
    int      errors  = 0;
    longint  cyc     = 0;
    logic    got_ok;
    logic [28:0] got_id;
    logic [63:0] got_data;
    logic [1:0]  got_src;
    longint      got_time;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] op, input int idx, input logic [28:0] id,
                           input logic ext, input logic rtr, input logic [63:0] data,
                           input int period, input logic en, input logic rchk);
        @(negedge clk);
        host_we = 1'b1; host_op = op; host_idx = 2'(idx); host_id = id; host_ext = ext;
        host_rtr = rtr; host_dlc = 4'd8; host_data = data; host_period = 14'(period);
        host_en = en; host_rtr_chk = rchk;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rx_pulse(input logic [28:0] id, input logic ext, input logic rtr);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_ext = ext; rx_rtr = rtr;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic serve(input int maxw);
        int w = 0;
        @(negedge clk);
        while (!tx_valid && w < maxw) begin
            @(negedge clk);
            w++;
        end
        got_ok = tx_valid;
        if (got_ok) begin
            got_id = tx_id; got_data = tx_data; got_src = tx_src; got_time = cyc;
            tx_take = 1'b1;
            @(negedge clk);
            tx_take = 1'b0; tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
        end
    endtask

    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1;
        end
        chk(req, "no offer expected", seen, 0);
    endtask

    // Dominance key from the rule in R2.
    function automatic longint bkey(input logic [28:0] id, input logic ext, input logic rtr);
        longint base, tail;
        base = ext ? longint'(id) / (longint'(1) << 18) : longint'(id) % 2048;
        tail = ext ? longint'(id) % (longint'(1) << 18) : 0;
        return base * (longint'(1) << 21) + (ext ? 1 : rtr) * (longint'(1) << 20)
             + ext * (longint'(1) << 19) + tail * 2 + (ext & rtr);
    endfunction

    logic [28:0] pid  [6];
    logic        pext [6];
    logic        prtr [6];

    initial begin
        repeat (150000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        pid[0] = 29'h123;       pext[0] = 0; prtr[0] = 0;
        pid[1] = 29'h123;       pext[1] = 0; prtr[1] = 1;
        pid[2] = 29'h48C0000;   pext[2] = 1; prtr[2] = 0;
        pid[3] = 29'h48C0000;   pext[3] = 1; prtr[3] = 1;
        pid[4] = 29'h122;       pext[4] = 0; prtr[4] = 0;
        pid[5] = 29'h48C0001;   pext[5] = 1; prtr[5] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "tx_valid after reset", tx_valid, 0);
        quiet("R1", 20);

        // R2 / R3 / R5 / R10: every ordered pair, direct vs queue.
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                longint ka, kb;
                bit dfirst;
                ka = bkey(pid[a], pext[a], prtr[a]);
                kb = bkey(pid[b], pext[b], prtr[b]);
                dfirst = (ka <= kb);
                host_wr(3'd0, 0, pid[b], pext[b], prtr[b], 64'hA0 + b, 0, 0, 0);
                host_wr(3'd1, 0, pid[a], pext[a], prtr[a], 64'hD0 + a, 0, 0, 0);
                repeat (3) @(negedge clk);
                serve(20);
                chk("R2", "first id", got_id, dfirst ? pid[a] : pid[b]);
                chk("R3", "first src", got_src, dfirst ? 0 : 3);
                serve(20);
                chk("R5", "second id", got_id, dfirst ? pid[b] : pid[a]);
                chk("R10", "second data", got_data, dfirst ? 64'hA0 + b : 64'hD0 + a);
            end
        end
        quiet("R5", 10);

        // R9: held in flight until done, nothing re-offered after retire.
        host_wr(3'd1, 0, 29'h77, 0, 0, 64'h99, 0, 0, 0);
        @(negedge clk);
        chk("R9", "offer valid", tx_valid, 1);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                if (tx_valid || tx_id != 29'h77) seen = 1;
                @(negedge clk);
            end
            chk("R9", "held while sending", seen, 0);
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk("R9", "idle cycle after done", tx_valid, 0);
        quiet("R9", 10);

        // R8: response matching.
        host_wr(3'd4, 0, 29'h300, 0, 0, 64'h1, 0, 0, 0);
        host_wr(3'd5, 0, 29'h55, 0, 1, 64'h0, 0, 1, 1);
        host_wr(3'd4, 1, 29'h301, 0, 0, 64'h2, 0, 0, 0);
        host_wr(3'd5, 1, 29'h1ABCDE, 1, 0, 64'h0, 0, 1, 0);
        rx_pulse(29'h55, 0, 0);
        quiet("R8", 6);
        rx_pulse(29'h55, 0, 1);
        serve(10);
        chk("R8", "resp0 id", got_id, 29'h300);
        chk("R8", "resp0 src", got_src, 1);
        rx_pulse(29'h4DE, 0, 1);
        quiet("R8", 6);
        rx_pulse(29'h55, 1, 1);
        quiet("R8", 6);
        rx_pulse(29'h1ABCDE, 1, 1);
        serve(10);
        chk("R8", "resp1 id", got_id, 29'h301);

        // R4: FIFO order and overflow drop.
        for (int i = 0; i <= QD; i++) begin
            host_wr(3'd0, 0, 29'(i * 3 + 7), 0, 0, 64'(i), 0, 0, 0);
        end
        for (int i = 0; i < QD; i++) begin
            serve(10);
            chk("R4", "queue order id", got_id, i * 3 + 7);
        end
        quiet("R4", 20);

        // R6 / R7: periodic entries.
        host_wr(3'd2, 0, 29'h10, 0, 0, 64'h1111, 0, 0, 0);
        host_wr(3'd2, 1, 29'h11, 0, 0, 64'h0, 0, 0, 0);
        host_wr(3'd2, 2, 29'h12, 0, 0, 64'h0, 0, 0, 0);
        host_wr(3'd3, 1, 0, 0, 0, 0, 0, 1, 0);
        host_wr(3'd3, 2, 0, 0, 0, 0, 2, 0, 0);
        host_wr(3'd3, 0, 0, 0, 0, 0, 3, 1, 0);
        begin
            longint t_prev;
            serve(100);
            chk("R6", "sched id", got_id, 29'h10);
            chk("R6", "sched src", got_src, 2);
            t_prev = got_time;
            serve(100);
            chk("R6", "period 1", got_time - t_prev, 3 * TICK);
            t_prev = got_time;
            host_wr(3'd2, 0, 29'h10, 0, 0, 64'hBEEF, 0, 0, 0);
            serve(100);
            chk("R7", "period kept", got_time - t_prev, 3 * TICK);
            chk("R7", "new data", got_data, 64'hBEEF);
            t_prev = got_time;
            serve(100);
            chk("R6", "period 3", got_time - t_prev, 3 * TICK);
        end
        host_wr(3'd3, 0, 0, 0, 0, 0, 3, 0, 0);
        quiet("R6", 100);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule